// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

The block walks a ring of transmit descriptors held in its own small descriptor store. Software fills each descriptor through a word-wide register port. A descriptor is two 32-bit words. Word 0 carries a 16-bit status field in bits [31:16] and a 16-bit byte count in bits [15:0]. Word 1 carries a 32-bit buffer address. Software hands a descriptor to the engine by setting its ready bit. The engine presents the buffer address, the byte count and two per-frame flags on a request/done frame interface. When the frame finishes, the engine writes the completion status back and clears the ready bit, which returns the descriptor to software.

The engine is a five-state machine:
- `S_HALT` moves to `S_FETCH` on a clear-halt write.
- `S_FETCH` moves to `S_SEND` when the descriptor is ready, to `S_HALT` when it is not, and to `S_STOPPED` when a graceful stop is requested.
- `S_SEND` moves to `S_RETURN` when the frame side reports done.
- `S_RETURN` writes the status back, then moves to `S_FETCH`, or to `S_STOPPED` when a stop is requested.
- `S_STOPPED` moves back to `S_FETCH` once the stop request is removed.

Status bits:
- bit 15: ready (engine owns the descriptor)
- bit 13: wrap (last descriptor of the ring)
- bit 12: interrupt on completion
- bit 11: last buffer of a frame
- bit 10: append CRC
- bits [3:0]: completion statistics written by the engine

Register map, on a 5-bit address with the default depth of 8:
- Addresses 0..15 select descriptor words. Address bit 0 picks the word and bits [3:1] pick the descriptor.
- Addresses 16..19 select the control registers:
  - 16, ring base: bits [2:0] give the index of descriptor 0.
  - 17, transmit status: a write with bit 0 set clears the halt. A read returns bit 0 halted, bit 1 stopped, and bits [10:8] the current index.
  - 18, control: bit 0 is the graceful stop request.
  - 19, event: bit 0 is stop-complete, cleared by writing 1.

Top module: `tx_desc_ring`

## Requirements
- R1: After reset the engine is in S_HALT with current index 0, frm_req and irq_done low, the stop event clear, the stop request clear and every descriptor word 0.
- R2: A register write to a descriptor word stores it, and a read of that address returns it. Word 0 is {status[15:0], length[15:0]} and word 1 is the buffer address.
- R3: While halted the engine raises no frame request. A write of 1 to transmit-status bit 0 starts fetching at the current index, and the frame request rises two clock edges after the write edge.
- R4: For a descriptor with ready (bit 15) set, frm_req stays high until frm_done. frm_ptr, frm_len, frm_crc (bit 10) and frm_last (bit 11) show that descriptor and do not change during the request.
- R5: On completion the engine rewrites status with ready cleared and bits [3:0] replaced by frm_stat. Status bits [14:4], the length and the buffer address are kept.
- R6: After a descriptor with the wrap bit (bit 13) the next fetch is at the ring base index. Otherwise the index advances by one, modulo the depth. A base write while halted or stopped also moves the current index to the base.
- R7: Reaching a descriptor with ready clear puts the engine in S_HALT with the index left on that descriptor. The next clear-halt write resumes there.
- R8: irq_done pulses for exactly one cycle per completed descriptor, only when its interrupt bit (bit 12) was set.
- R9: A graceful stop request raised during a frame lets that frame complete and return. The engine then enters S_STOPPED, sets the stop event and starts no further frame. Clearing the request resumes fetching at the next index.
- R10: Writing 1 to event bit 0 clears the stop event, provided no new stop completes in the same cycle.
- R11: A stop request while in S_HALT sets the stop event on the next edge without leaving S_HALT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 5 | Register address (IDX_W+2 bits) |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data, combinational from cfg_addr |
| frm_req | output | 1 | Frame request, held until frm_done |
| frm_ptr | output | 32 | Buffer address of the requested frame |
| frm_len | output | 16 | Byte count of the requested frame |
| frm_crc | output | 1 | Append-CRC flag of the requested frame |
| frm_last | output | 1 | Last-buffer flag of the requested frame |
| frm_done | input | 1 | Frame finished; sampled while frm_req is high |
| frm_stat | input | 4 | Completion statistics captured with frm_done |
| irq_done | output | 1 | One-cycle completion interrupt |

## Verification
The bench builds the block with the default depth of 8, so the ring base and ring length can both be chosen at random in every round. With a depth of 8, rings that cross the top of the store and fold back to index 0 occur within a handful of rounds, and the modulo advance is exercised alongside the wrap-to-base return. A 4-bit statistics field keeps the rewritten status fully predictable. Random rings from random bases with random flags are mixed with directed cases: a halt in mid-ring, a graceful stop taken during a frame, and a stop requested while already halted.

// File: rtl/tdr_pkg.sv
package tdr_pkg;
    // status word bit positions (upper half of descriptor word 0)
    localparam int ST_READY = 15;
    localparam int ST_WRAP  = 13;
    localparam int ST_INTR  = 12;
    localparam int ST_LAST  = 11;
    localparam int ST_CRC   = 10;
    // statistics field occupies status bits [KEEP_LO-1:0]
    localparam int KEEP_LO  = 4;
    localparam int KEEP_W   = ST_READY - KEEP_LO;
    localparam int STAT_W   = KEEP_LO;

    localparam logic [1:0] REG_BASE  = 2'd0;
    localparam logic [1:0] REG_TSTAT = 2'd1;
    localparam logic [1:0] REG_CTRL  = 2'd2;
    localparam logic [1:0] REG_EVENT = 2'd3;

    typedef enum logic [2:0] {
        S_HALT    = 3'd0,
        S_FETCH   = 3'd1,
        S_SEND    = 3'd2,
        S_RETURN  = 3'd3,
        S_STOPPED = 3'd4
    } eng_state_t;
endpackage

// File: rtl/tdr_desc_mem.sv
module tdr_desc_mem
    import tdr_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int IDX_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_we,
    input  logic [IDX_W-1:0]  sw_idx,
    input  logic              sw_word,
    input  logic [31:0]       sw_wdata,
    output logic [31:0]       sw_rdata,
    input  logic [IDX_W-1:0]  eng_idx,
    input  logic              eng_we,
    input  logic [KEEP_W-1:0] eng_keep_wr,
    input  logic [STAT_W-1:0] eng_stat_wr,
    output logic              eng_ready,
    output logic [KEEP_W-1:0] eng_keep,
    output logic [15:0]       eng_len,
    output logic [31:0]       eng_ptr
);
    logic [31:0] sl_q  [DEPTH];
    logic [31:0] ptr_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sl_q[g]  <= '0;
                ptr_q[g] <= '0;
            end else begin
                // engine write-back takes word 0 over a same-cycle software write
                if (eng_we && eng_idx == IDX_W'(g)) begin
                    sl_q[g][31:16] <= {1'b0, eng_keep_wr, eng_stat_wr};
                end else if (sw_we && !sw_word && sw_idx == IDX_W'(g)) begin
                    sl_q[g] <= sw_wdata;
                end
                if (sw_we && sw_word && sw_idx == IDX_W'(g)) begin
                    ptr_q[g] <= sw_wdata;
                end
            end
        end
    end

    always_comb begin
        sw_rdata  = sw_word ? ptr_q[sw_idx] : sl_q[sw_idx];
        eng_ready = sl_q[eng_idx][16 + ST_READY];
        eng_keep  = sl_q[eng_idx][16 + KEEP_LO +: KEEP_W];
        eng_len   = sl_q[eng_idx][15:0];
        eng_ptr   = ptr_q[eng_idx];
    end
endmodule

// File: rtl/tdr_regs.sv
module tdr_regs
    import tdr_pkg::*;
#(
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [1:0]       sel,
    input  logic [IDX_W-1:0] wbits,
    input  logic             stop_set,
    input  logic             halted,
    input  logic             stopped,
    input  logic [IDX_W-1:0] cur_idx,
    output logic [IDX_W-1:0] base_idx,
    output logic             base_wr,
    output logic [IDX_W-1:0] base_wval,
    output logic             clr_halt,
    output logic             gts_req,
    output logic             stop_evt,
    output logic [31:0]      rdata
);
    logic evt_clr;

    always_comb begin
        base_wr   = wr && sel == REG_BASE;
        base_wval = wbits;
        clr_halt  = wr && sel == REG_TSTAT && wbits[0];
        evt_clr   = wr && sel == REG_EVENT && wbits[0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_idx <= '0;
            gts_req  <= 1'b0;
            stop_evt <= 1'b0;
        end else begin
            if (base_wr) begin
                base_idx <= wbits;
            end
            if (wr && sel == REG_CTRL) begin
                gts_req <= wbits[0];
            end
            if (stop_set) begin
                stop_evt <= 1'b1;
            end else if (evt_clr) begin
                stop_evt <= 1'b0;
            end
        end
    end

    always_comb begin
        rdata = '0;
        unique case (sel)
            REG_BASE:  rdata[IDX_W-1:0] = base_idx;
            REG_TSTAT: begin
                rdata[0]          = halted;
                rdata[1]          = stopped;
                rdata[8 +: IDX_W] = cur_idx;
            end
            REG_CTRL:  rdata[0] = gts_req;
            REG_EVENT: rdata[0] = stop_evt;
            default:   rdata = '0;
        endcase
    end

    AST_EVT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        evt_clr && !stop_set |=> !stop_evt); // R10
endmodule

// File: rtl/tdr_fsm.sv
module tdr_fsm
    import tdr_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int IDX_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_halt,
    input  logic              base_wr,
    input  logic [IDX_W-1:0]  base_wval,
    input  logic [IDX_W-1:0]  base_idx,
    input  logic              gts_req,
    input  logic              desc_ready,
    input  logic [KEEP_W-1:0] desc_keep,
    input  logic [15:0]       desc_len,
    input  logic [31:0]       desc_ptr,
    input  logic              frm_done,
    input  logic [STAT_W-1:0] frm_stat,
    output logic [IDX_W-1:0]  cur_idx,
    output logic              eng_we,
    output logic [KEEP_W-1:0] eng_keep_wr,
    output logic [STAT_W-1:0] eng_stat_wr,
    output logic              frm_req,
    output logic [31:0]       frm_ptr,
    output logic [15:0]       frm_len,
    output logic              frm_crc,
    output logic              frm_last,
    output logic              irq_done,
    output logic              halted,
    output logic              stopped,
    output logic              stop_set
);
    localparam int W_BIT = ST_WRAP - KEEP_LO;
    localparam int I_BIT = ST_INTR - KEEP_LO;
    localparam int L_BIT = ST_LAST - KEEP_LO;
    localparam int C_BIT = ST_CRC - KEEP_LO;

    eng_state_t        state, nxt;
    logic [KEEP_W-1:0] lat_keep;
    logic [15:0]       lat_len;
    logic [31:0]       lat_ptr;
    logic [STAT_W-1:0] lat_stat;
    logic [IDX_W-1:0]  seq_idx;

    always_comb begin
        nxt = state;
        unique case (state)
            S_HALT:    if (clr_halt) nxt = S_FETCH;
            S_FETCH: begin
                if (gts_req)         nxt = S_STOPPED;
                else if (desc_ready) nxt = S_SEND;
                else                 nxt = S_HALT;
            end
            S_SEND:    if (frm_done) nxt = S_RETURN;
            S_RETURN:  nxt = gts_req ? S_STOPPED : S_FETCH;
            S_STOPPED: if (!gts_req) nxt = S_FETCH;
            default:   nxt = S_HALT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_HALT;
        else        state <= nxt;
    end

    always_comb begin
        seq_idx = (cur_idx == IDX_W'(DEPTH - 1)) ? '0 : cur_idx + IDX_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_idx  <= '0;
            lat_keep <= '0;
            lat_len  <= '0;
            lat_ptr  <= '0;
            lat_stat <= '0;
        end else begin
            if (base_wr && (state == S_HALT || state == S_STOPPED)) begin
                cur_idx <= base_wval;
            end else if (state == S_RETURN) begin
                cur_idx <= lat_keep[W_BIT] ? base_idx : seq_idx;
            end
            if (state == S_FETCH && desc_ready && !gts_req) begin
                lat_keep <= desc_keep;
                lat_len  <= desc_len;
                lat_ptr  <= desc_ptr;
            end
            if (state == S_SEND && frm_done) begin
                lat_stat <= frm_stat;
            end
        end
    end

    always_comb begin
        frm_req     = state == S_SEND;
        frm_ptr     = lat_ptr;
        frm_len     = lat_len;
        frm_crc     = lat_keep[C_BIT];
        frm_last    = lat_keep[L_BIT];
        eng_we      = state == S_RETURN;
        eng_keep_wr = lat_keep;
        eng_stat_wr = lat_stat;
        irq_done    = state == S_RETURN && lat_keep[I_BIT];
        halted      = state == S_HALT;
        stopped     = state == S_STOPPED;
        stop_set    = (state == S_HALT && gts_req) ||
                      (state != S_STOPPED && nxt == S_STOPPED);
    end

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        frm_req && !frm_done |=> frm_req && $stable(frm_ptr) && $stable(frm_len)); // R4
    AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_done |=> !irq_done); // R8
    AST_WRAP_TO_BASE: assert property (@(posedge clk) disable iff (!rst_n)
        state == S_RETURN && lat_keep[W_BIT] |=> cur_idx == $past(base_idx)); // R6
    AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !frm_req && !eng_we && !irq_done); // R7
endmodule

// File: rtl/tx_desc_ring.sv
module tx_desc_ring
    import tdr_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int AW    = IDX_W + 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_wr,
    input  logic [AW-1:0] cfg_addr,
    input  logic [31:0]   cfg_wdata,
    output logic [31:0]   cfg_rdata,
    output logic          frm_req,
    output logic [31:0]   frm_ptr,
    output logic [15:0]   frm_len,
    output logic          frm_crc,
    output logic          frm_last,
    input  logic          frm_done,
    input  logic [3:0]    frm_stat,
    output logic          irq_done
);
    logic              ctl_sel;
    logic [31:0]       mem_rdata, reg_rdata;
    logic [IDX_W-1:0]  cur_idx, base_idx, base_wval;
    logic              base_wr, clr_halt, gts_req, stop_evt;
    logic              halted, stopped, stop_set;
    logic              eng_we, desc_ready;
    logic [KEEP_W-1:0] eng_keep_wr, desc_keep;
    logic [STAT_W-1:0] eng_stat_wr;
    logic [15:0]       desc_len;
    logic [31:0]       desc_ptr;

    always_comb begin
        ctl_sel   = cfg_addr[AW-1];
        cfg_rdata = ctl_sel ? reg_rdata : mem_rdata;
    end

    tdr_desc_mem #(.DEPTH(DEPTH), .IDX_W(IDX_W)) i_mem (
        .clk(clk), .rst_n(rst_n),
        .sw_we(cfg_wr && !ctl_sel), .sw_idx(cfg_addr[AW-2:1]), .sw_word(cfg_addr[0]),
        .sw_wdata(cfg_wdata), .sw_rdata(mem_rdata),
        .eng_idx(cur_idx), .eng_we(eng_we), .eng_keep_wr(eng_keep_wr),
        .eng_stat_wr(eng_stat_wr), .eng_ready(desc_ready), .eng_keep(desc_keep),
        .eng_len(desc_len), .eng_ptr(desc_ptr)
    );

    tdr_regs #(.IDX_W(IDX_W)) i_regs (
        .clk(clk), .rst_n(rst_n),
        .wr(cfg_wr && ctl_sel), .sel(cfg_addr[1:0]), .wbits(cfg_wdata[IDX_W-1:0]),
        .stop_set(stop_set), .halted(halted), .stopped(stopped), .cur_idx(cur_idx),
        .base_idx(base_idx), .base_wr(base_wr), .base_wval(base_wval),
        .clr_halt(clr_halt), .gts_req(gts_req), .stop_evt(stop_evt), .rdata(reg_rdata)
    );

    tdr_fsm #(.DEPTH(DEPTH), .IDX_W(IDX_W)) i_fsm (
        .clk(clk), .rst_n(rst_n),
        .clr_halt(clr_halt), .base_wr(base_wr), .base_wval(base_wval), .base_idx(base_idx),
        .gts_req(gts_req), .desc_ready(desc_ready), .desc_keep(desc_keep),
        .desc_len(desc_len), .desc_ptr(desc_ptr), .frm_done(frm_done), .frm_stat(frm_stat),
        .cur_idx(cur_idx), .eng_we(eng_we), .eng_keep_wr(eng_keep_wr),
        .eng_stat_wr(eng_stat_wr), .frm_req(frm_req), .frm_ptr(frm_ptr), .frm_len(frm_len),
        .frm_crc(frm_crc), .frm_last(frm_last), .irq_done(irq_done),
        .halted(halted), .stopped(stopped), .stop_set(stop_set)
    );

    AST_STOP_AFTER_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stop_evt) |-> !frm_req); // R9
    AST_RESET_HALTED: assert property (@(posedge clk)
        !rst_n |=> halted && !frm_req); // R1
endmodule

// File: tb/test_tx_desc_ring.sv
module test_tx_desc_ring;
    localparam int D = 8;
    localparam int ADR_CTL = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [4:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        frm_req, frm_crc, frm_last, irq_done;
    logic [31:0] frm_ptr;
    logic [15:0] frm_len;
    logic        frm_done = 1'b0;
    logic [3:0]  frm_stat = '0;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    logic [15:0] m_st  [D];
    logic [15:0] m_len [D];
    logic [31:0] m_ptr [D];
    int m_base = 0;

    always #5 clk = ~clk;

    tx_desc_ring i_tx_desc_ring (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .frm_req(frm_req),
        .frm_ptr(frm_ptr), .frm_len(frm_len), .frm_crc(frm_crc), .frm_last(frm_last),
        .frm_done(frm_done), .frm_stat(frm_stat), .irq_done(irq_done)
    );

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            total++; bad++;
            $display("FAIL watchdog: act=%0d cycles exp<=100000", cyc);
            finish_run();
        end
    end

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input int addr, input logic [31:0] data);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = 5'(addr); cfg_wdata = data;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic rd(input int addr, output logic [31:0] data);
        cfg_addr = 5'(addr);
        #1;
        data = cfg_rdata;
    endtask

    function automatic int nxt_idx(input int i);
        if (m_st[i][13]) return m_base;
        return (i + 1) % D;
    endfunction

    function automatic logic [15:0] ret_status(input logic [15:0] s, input logic [3:0] st);
        return {1'b0, s[14:4], st};
    endfunction

    task automatic put_desc(input int i, input logic [15:0] st, input logic [15:0] len, input logic [31:0] p);
        m_st[i] = st; m_len[i] = len; m_ptr[i] = p;
        wr(2 * i, {st, len});
        wr(2 * i + 1, p);
    endtask

    // R4, R5, R8: serve one frame of descriptor i
    task automatic serve(input int i, input logic [3:0] st);
        int t = 0;
        while (!frm_req && t < 50) begin
            @(negedge clk); t++;
        end
        chk(frm_req, "R4 frame request", 32'(frm_req), 32'd1);
        chk(frm_ptr == m_ptr[i], "R4 pointer", frm_ptr, m_ptr[i]);
        chk(frm_len == m_len[i], "R4 length", 32'(frm_len), 32'(m_len[i]));
        chk({frm_crc, frm_last} == {m_st[i][10], m_st[i][11]}, "R4 crc/last flags",
            32'({frm_crc, frm_last}), 32'({m_st[i][10], m_st[i][11]}));
        frm_done = 1'b1; frm_stat = st;
        @(negedge clk);
        frm_done = 1'b0;
        chk(irq_done == m_st[i][12], "R8 irq in return cycle", 32'(irq_done), 32'(m_st[i][12]));
        m_st[i] = ret_status(m_st[i], st);
        @(negedge clk);
        chk(!irq_done, "R8 irq single cycle", 32'(irq_done), 32'd0);
    endtask

    task automatic chk_desc(input int i);
        logic [31:0] v;
        rd(2 * i, v);
        chk(v == {m_st[i], m_len[i]}, "R5 returned word0", v, {m_st[i], m_len[i]});
        rd(2 * i + 1, v);
        chk(v == m_ptr[i], "R5 pointer kept", v, m_ptr[i]);
    endtask

    task automatic chk_halt(input int i, input string tag);
        logic [31:0] v;
        @(negedge clk); @(negedge clk);
        rd(ADR_CTL + 1, v);
        chk(v[0] == 1'b1 && v[10:8] == 3'(i), tag, v, {21'd0, 3'(i), 8'd1});
        chk(!frm_req, tag, 32'(frm_req), 32'd0);
    endtask

    initial begin
        logic [31:0] v;
        void'($urandom(32'h1357));
        for (int i = 0; i < D; i++) begin
            m_st[i] = '0; m_len[i] = '0; m_ptr[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(!frm_req && !irq_done, "R1 outputs idle", 32'({frm_req, irq_done}), 32'd0);
        rd(ADR_CTL + 1, v); chk(v == 32'd1, "R1 halted at index 0", v, 32'd1);
        rd(ADR_CTL + 3, v); chk(v == 32'd0, "R1 event clear", v, 32'd0);
        rd(ADR_CTL + 2, v); chk(v == 32'd0, "R1 stop request clear", v, 32'd0);
        rd(5, v); chk(v == 32'd0, "R1 descriptor zero", v, 32'd0);

        // R2 descriptor write / read back
        put_desc(0, 16'h8c00, 16'd64, 32'h1000_0000);
        put_desc(1, 16'h8800, 16'd128, 32'h1000_0100);
        put_desc(2, 16'h2000, 16'd60, 32'h1000_0200);
        rd(2, v); chk(v == {16'h8800, 16'd128}, "R2 word0 readback", v, {16'h8800, 16'd128});
        rd(3, v); chk(v == 32'h1000_0100, "R2 word1 readback", v, 32'h1000_0100);

        // R3 no request while halted
        repeat (5) @(negedge clk);
        chk(!frm_req, "R3 quiet while halted", 32'(frm_req), 32'd0);
        wr(ADR_CTL + 1, 32'd1);
        // the write edge was just before this negedge; request rises on the second edge after it
        chk(!frm_req, "R3 no request one edge after write", 32'(frm_req), 32'd0);
        @(negedge clk);
        chk(frm_req, "R3 request two edges after write", 32'(frm_req), 32'd1);
        serve(0, 4'h3);
        serve(1, 4'h0);
        // R7 halt on descriptor 2 (not ready)
        chk_halt(2, "R7 halt on non-ready");
        chk_desc(0); chk_desc(1);
        m_st[2] = 16'hb000;
        wr(4, {16'hb000, 16'd60});
        wr(ADR_CTL + 1, 32'd1);
        serve(2, 4'h5);
        // R6 wrap from 2 goes to base 0, not ready -> halt at 0
        chk_halt(0, "R6 wrap to base");
        chk_desc(2);

        // R9 graceful stop during a frame
        m_base = 3;
        wr(ADR_CTL + 0, 32'd3);
        put_desc(3, 16'h9000, 16'd200, 32'h2000_0000);
        put_desc(4, 16'ha400, 16'd300, 32'h2000_1000);
        wr(ADR_CTL + 1, 32'd1);
        while (!frm_req) @(negedge clk);
        wr(ADR_CTL + 2, 32'd1);
        chk(frm_req, "R9 frame kept while stop pending", 32'(frm_req), 32'd1);
        serve(3, 4'h9);
        repeat (3) @(negedge clk);
        chk(!frm_req, "R9 no frame after stop", 32'(frm_req), 32'd0);
        rd(ADR_CTL + 3, v); chk(v[0], "R9 stop event set", v, 32'd1);
        rd(ADR_CTL + 1, v); chk(v[1] && v[10:8] == 3'd4, "R9 stopped at next index", v, 32'h402);
        chk_desc(3);
        wr(ADR_CTL + 2, 32'd0);
        serve(4, 4'h1);
        chk_halt(3, "R6 ring of two wraps to base 3");
        chk_desc(4);
        // R10 event clear
        wr(ADR_CTL + 3, 32'd1);
        rd(ADR_CTL + 3, v); chk(v == 32'd0, "R10 event cleared", v, 32'd0);

        // R11 stop request while halted
        wr(ADR_CTL + 2, 32'd1);
        @(negedge clk);
        rd(ADR_CTL + 3, v); chk(v[0], "R11 event while halted", v, 32'd1);
        rd(ADR_CTL + 1, v); chk(v[0] && !v[1], "R11 still halted", v, 32'h301);
        wr(ADR_CTL + 2, 32'd0);
        wr(ADR_CTL + 3, 32'd1);
        rd(ADR_CTL + 3, v); chk(v == 32'd0, "R10 event cleared again", v, 32'd0);

        // random rings from random bases
        for (int r = 0; r < 12; r++) begin
            int b = $urandom % D;
            int n = 1 + ($urandom % 5);
            m_base = b;
            wr(ADR_CTL + 0, 32'(b));
            rd(ADR_CTL + 1, v); chk(v[10:8] == 3'(b), "R6 base moves index", v, 32'(b) << 8);
            for (int k = 0; k < n; k++) begin
                int i = (b + k) % D;
                logic [15:0] s = 16'h8000 | (16'($urandom) & 16'h1c0f);
                if (k == n - 1) s = s | 16'h2000;
                put_desc(i, s, 16'($urandom), $urandom);
            end
            wr(ADR_CTL + 1, 32'd1);
            for (int k = 0; k < n; k++) begin
                int i = (b + k) % D;
                serve(i, 4'($urandom));
                chk(nxt_idx(i) == ((k == n - 1) ? b : (b + k + 1) % D), "R6 model walk",
                    32'(nxt_idx(i)), 32'(b));
            end
            chk_halt(b, "R6 random ring halts at base");
            for (int k = 0; k < n; k++) chk_desc((b + k) % D);
        end

        finish_run();
    end
endmodule